// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through a small word-addressed register port. Software pushes words into a transmit queue and pops received words from a receive queue. Each queue holds 64 words. A control register sets the enable, the active select line, the word length and the SCLK divider. Writing the exchange bit sends every queued word as one burst on the selected line.

Each of the four select lines has its own settings for clock phase, clock polarity, SCLK idle level and select polarity. These settings live in a configuration register. The engine shifts the low bits of each queued word out MSB first and shifts the same number of bits in. For every word sent, it stores one right-aligned word in the receive queue. A status register shows whether the transmit queue is empty and whether receive data is waiting. The interrupt output is the OR of each status condition whose enable bit is set.

Register map (word address on `reg_addr`): 0 receive data (a read pops one word), 1 transmit data (a write pushes one word), 2 control, 3 select configuration, 4 interrupt enable, 5 status.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, control, configuration and interrupt-enable read as zero, status reads 0x1 (transmit empty), `irq` is 0, `sclk` is 0 and `sel_out` is 4'hF.
- R2: Each queue holds 64 words. A transmit-data write is dropped while 64 words wait. A receive-data read returns 0 and pops nothing when the receive queue is empty.
- R3: Control bit 0 is the enable and bit 2 is the exchange bit. Writing 1 to bit 2 together with bit 0 starts a burst, and bit 2 reads back 1 until the transmit queue is empty and the last word has finished. An exchange write while bit 0 is 0 is ignored. Writing 0 to bit 0 stops the burst.
- R4: SCLK edges within a word are spaced (pre+1)·2^post clock cycles apart. `pre` is control bits 15:12 and `post` is control bits 11:8.
- R5: The word length is (control bits 24:20)+1, from 1 to 32. Data leaves MSB first, starting from the top bit of the word's low (length) bits. Upper bits of the queue entry are ignored.
- R6: Control bits 19:18 select line n. For the whole burst, only `sel_out[n]` is at its active level, given by configuration bit n+12 (1 = active high). Every other line sits at the inverse of its own bit.
- R7: Configuration bit n sets the phase for line n: 0 samples MISO on the leading edge, 1 samples it on the trailing edge. Bit n+4 sets the SCLK level during the burst. Bit n+20 sets the SCLK level while no burst runs.
- R8: Status bit 0 is 1 while the transmit queue is empty, and status bit 3 is 1 while the receive queue holds a word. `irq` = (enable bit 0 AND status bit 0) OR (enable bit 3 AND status bit 3).
- R9: Every sent word produces exactly one received word, right-aligned and zero above the length. When the receive queue is full, the engine waits and overwrites nothing.
- R10: Control reads back bits 24:18, 15:4, 2 and 0, with zeros elsewhere. Configuration reads back bits 23:20 and 15:0, with zeros elsewhere. Control bits 7:4 are stored only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on receive-data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_out | output | 4 | Select lines, polarity per line |

## Verification
The bench loops MOSI back to MISO. It runs every phase and polarity combination with lengths of 1, 5, 8, 12, 16 and 32 bits. If the sample and shift edges were swapped, the loopback word would come back shifted. If the bit order or alignment were wrong, the serial capture at the sampling edge would not match. The bench measures the spacing of SCLK edges against the divider fields, which exposes an off-by-one in either stage. It overfills the transmit queue and then re-runs with a full receive queue. A design that overwrote data would lose the oldest received word, and one that dropped its hold would clear the exchange bit early.

// File: rtl/spi_ctl_pkg.sv
`timescale 1ns/1ps
package spi_ctl_pkg;
    localparam int WORD_W  = 32;
    localparam int NUM_SEL = 4;

    typedef enum logic [2:0] {
        A_RXD   = 3'd0,
        A_TXD   = 3'd1,
        A_CTRL  = 3'd2,
        A_CFG   = 3'd3,
        A_IRQEN = 3'd4,
        A_STAT  = 3'd5
    } reg_addr_e;

    localparam int C_EN  = 0;
    localparam int C_XCH = 2;
    localparam logic [31:0] CFG_KEEP = 32'h00F0_FFFF;
endpackage

// File: rtl/spi_word_fifo.sv
`timescale 1ns/1ps
module spi_word_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (do_push && !do_pop) st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R2
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (st_q.cnt == $past(st_q.cnt))); // R2
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tx_empty,
    input  logic [W-1:0]      tx_word,
    input  logic              rx_full,
    input  logic [$clog2(W)-1:0] len_m1,
    input  logic [3:0]        pre,
    input  logic [3:0]        post,
    input  logic              pha,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [W-1:0]      rx_word,
    output logic              mosi,
    output logic              edge_phase,
    output logic              busy
);
    localparam int LW  = $clog2(W);
    localparam int ECW = LW + 1;

    typedef struct packed {
        logic           active;
        logic           phase;
        logic [ECW-1:0] edge_cnt;
        logic [3:0]     pre_cnt;
        logic [15:0]    post_cnt;
        logic [W-1:0]   shreg;
        logic [W-1:0]   rxreg;
    } eng_st_t;

    eng_st_t st_d, st_q;
    logic [15:0]    post_lim;
    logic [ECW-1:0] last_edge;
    logic           tick;

    assign post_lim  = (16'd1 << post) - 16'd1;
    assign last_edge = {len_m1, 1'b1};
    assign tick      = st_q.active && (st_q.pre_cnt == pre) && (st_q.post_cnt == post_lim);

    always_comb begin
        st_d    = st_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        if (!st_q.active) begin
            if (run && !tx_empty && !rx_full) begin
                tx_pop        = 1'b1;
                st_d.active   = 1'b1;
                st_d.phase    = 1'b0;
                st_d.edge_cnt = '0;
                st_d.pre_cnt  = '0;
                st_d.post_cnt = '0;
                st_d.shreg    = tx_word << (LW'(W - 1) - len_m1);
                st_d.rxreg    = '0;
            end
        end else begin
            if (st_q.pre_cnt == pre) begin
                st_d.pre_cnt  = '0;
                st_d.post_cnt = (st_q.post_cnt == post_lim) ? '0 : st_q.post_cnt + 16'd1;
            end else begin
                st_d.pre_cnt = st_q.pre_cnt + 4'd1;
            end
            if (tick) begin
                st_d.phase = ~st_q.phase;
                if (st_q.edge_cnt[0] == pha)
                    st_d.rxreg = {st_q.rxreg[W-2:0], miso};
                else if (!pha || (st_q.edge_cnt != '0))
                    st_d.shreg = st_q.shreg << 1;
                if (st_q.edge_cnt == last_edge) begin
                    st_d.active = 1'b0;
                    rx_push     = 1'b1;
                end else begin
                    st_d.edge_cnt = st_q.edge_cnt + 1'b1;
                end
            end
        end
    end

    assign rx_word    = st_d.rxreg;
    assign mosi       = st_q.shreg[W-1];
    assign edge_phase = st_q.phase;
    assign busy       = st_q.active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R9
    AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.edge_cnt <= last_edge)); // R5
    AST_PHASE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> !st_q.phase); // R7
endmodule

// File: rtl/spi_regmaster.sv
`timescale 1ns/1ps
module spi_regmaster
    import spi_ctl_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  sel_out
);
    localparam int LW = $clog2(WORD_W);

    typedef struct packed {
        logic          en;
        logic          xch;
        logic [3:0]    master;
        logic [3:0]    post;
        logic [3:0]    pre;
        logic [1:0]    cs;
        logic [LW-1:0] len_m1;
        logic [31:0]   cfg;
        logic          ie_tx;
        logic          ie_rx;
    } regs_t;

    regs_t r_d, r_q;

    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic              tx_pop, rx_push, eng_busy, eng_phase;
    logic              burst, rx_ready;
    logic [3:0]        pha_v, pol_v, spol_v, idle_v;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[31:25], reg_wdata[17:16], reg_wdata[3], reg_wdata[1], tx_full};

    spi_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_txq (
        .clk(clk), .rst_n(rst_n),
        .push(reg_wr && (reg_addr == A_TXD)), .push_data(reg_wdata),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
    );

    spi_word_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_word),
        .pop(reg_rd && (reg_addr == A_RXD)), .head(rx_head), .empty(rx_empty), .full(rx_full)
    );

    assign pha_v  = r_q.cfg[3:0];
    assign pol_v  = r_q.cfg[7:4];
    assign spol_v = r_q.cfg[15:12];
    assign idle_v = r_q.cfg[23:20];

    spi_shift_engine #(.W(WORD_W)) i_eng (
        .clk(clk), .rst_n(rst_n),
        .run(r_q.en && r_q.xch),
        .tx_empty(tx_empty), .tx_word(tx_head), .rx_full(rx_full),
        .len_m1(r_q.len_m1), .pre(r_q.pre), .post(r_q.post),
        .pha(pha_v[r_q.cs]), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .mosi(mosi), .edge_phase(eng_phase), .busy(eng_busy)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.xch && !eng_busy && tx_empty) r_d.xch = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    r_d.en     = reg_wdata[C_EN];
                    r_d.master = reg_wdata[7:4];
                    r_d.post   = reg_wdata[11:8];
                    r_d.pre    = reg_wdata[15:12];
                    r_d.cs     = reg_wdata[19:18];
                    r_d.len_m1 = reg_wdata[24:20];
                    if (reg_wdata[C_EN] && reg_wdata[C_XCH]) r_d.xch = 1'b1;
                end
                A_CFG:   r_d.cfg = reg_wdata & CFG_KEEP;
                A_IRQEN: begin
                    r_d.ie_tx = reg_wdata[0];
                    r_d.ie_rx = reg_wdata[3];
                end
                default: ;
            endcase
        end
        if (!r_d.en) r_d.xch = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign burst    = r_q.xch || eng_busy;
    assign rx_ready = !rx_empty;
    assign sclk     = burst ? (pol_v[r_q.cs] ^ eng_phase) : idle_v[r_q.cs];
    assign irq      = (r_q.ie_tx && tx_empty) || (r_q.ie_rx && rx_ready);

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel_out[g] = (burst && (r_q.cs == 2'(g))) ? spol_v[g] : ~spol_v[g];
    end

    always_comb begin
        case (reg_addr)
            A_RXD:   reg_rdata = rx_empty ? 32'd0 : rx_head;
            A_CTRL:  reg_rdata = {7'd0, r_q.len_m1, r_q.cs, 2'd0, r_q.pre, r_q.post,
                                  r_q.master, 1'b0, r_q.xch, 1'b0, r_q.en};
            A_CFG:   reg_rdata = r_q.cfg;
            A_IRQEN: reg_rdata = {28'd0, r_q.ie_rx, 2'd0, r_q.ie_tx};
            A_STAT:  reg_rdata = {28'd0, rx_ready, 2'd0, tx_empty};
            default: reg_rdata = 32'd0;
        endcase
    end

    AST_XCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.xch) |-> r_q.en); // R3
    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(r_q.xch) && r_q.en) |-> $past(tx_empty)); // R3
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~(sel_out ^ spol_v)) <= 1); // R6
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && $past(burst) && $stable(r_q.cfg)) |-> $stable(sel_out)); // R6
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_empty || !rx_empty)); // R8
endmodule

// File: tb/test_spi_regmaster.sv
`timescale 1ns/1ps
module test_spi_regmaster;
    localparam logic [2:0] RXD = 3'd0, TXD = 3'd1, CTRL = 3'd2, CFG = 3'd3, IEN = 3'd4, STAT = 3'd5;

    typedef struct packed {
        logic        pol;
        logic        pha;
        logic [4:0]  lm1;
        logic [3:0]  pre;
        logic [3:0]  post;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 5'd7,  4'd0, 4'd0, 32'hFFFF_FFA5},
        '{1'b0, 1'b1, 5'd15, 4'd1, 4'd0, 32'h1234_C3E1},
        '{1'b1, 1'b0, 5'd0,  4'd0, 4'd1, 32'hFFFF_FFFE},
        '{1'b1, 1'b1, 5'd31, 4'd2, 4'd1, 32'h8000_0001},
        '{1'b0, 1'b0, 5'd4,  4'd3, 4'd2, 32'h0000_0013},
        '{1'b1, 1'b0, 5'd11, 4'd0, 4'd0, 32'hABCD_E5A6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, sclk, mosi, miso;
    logic [3:0]  sel_out;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;
    assign miso = mosi;

    spi_regmaster i_spi_regmaster (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .sel_out(sel_out)
    );

    // serial monitor: edge spacing and capture at the sampling edge
    int          cyc = 0, last_edge = 0, space_err = 0, exp_n = 1;
    bit          have_edge = 0, mon_en = 0, cap_rise = 0;
    logic        sclk_prev = 1'b0;
    logic [31:0] cap = '0;

    always @(negedge clk) begin
        cyc++;
        if (!mon_en) begin
            have_edge = 0; space_err = 0; cap = '0;
        end else if (sclk !== sclk_prev) begin
            if (have_edge && (cyc - last_edge) != exp_n) space_err++;
            have_edge = 1;
            last_edge = cyc;
            if (sclk == cap_rise) cap = {cap[30:0], mosi};
        end
        sclk_prev = sclk;
    end

    bit finished = 0;
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", wd);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        bit ok;
        ok = 0;
        for (int k = 0; k < 6000; k++) begin
            rd(CTRL, v);
            if (!v[2]) begin ok = 1; break; end
        end
        chk(req, 32'(ok), 32'd1);
    endtask

    initial begin
        logic [31:0] v, expw, cfgw;
        int          cs, len;
        logic        spol;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTRL, v);  chk("R1 ctrl", v, 32'd0);
        rd(CFG, v);   chk("R1 cfg", v, 32'd0);
        rd(IEN, v);   chk("R1 irq enable", v, 32'd0);
        rd(STAT, v);  chk("R1 status", v, 32'h1);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 sclk", 32'(sclk), 32'd0);
        chk("R1 sel_out", 32'(sel_out), 32'hF);

        // R10 readback
        wr(CTRL, 32'h01FC_A5F0);
        rd(CTRL, v);  chk("R10 ctrl readback", v, 32'h01FC_A5F0);
        wr(CFG, 32'hFFFF_FFFF);
        rd(CFG, v);   chk("R10 cfg readback", v, 32'h00F0_FFFF);
        wr(CFG, 32'd0);
        wr(CTRL, 32'd0);

        // R3 exchange while disabled is ignored
        wr(TXD, 32'h0000_0001);
        wr(CTRL, 32'h4);
        rd(CTRL, v);  chk("R3 xch ignored when disabled", v, 32'd0);
        repeat (30) @(negedge clk);
        rd(STAT, v);  chk("R3 nothing shifted when disabled", v, 32'd0);
        chk("R3 no select when disabled", 32'(sel_out), 32'hF);
        wr(CTRL, 32'h5);
        wait_done("R3 xch self clears");
        rd(RXD, v);   chk("R3 word after enable", v, 32'd1);

        // table of modes, lengths and divider settings (R4 R5 R6 R7 R9)
        for (int i = 0; i < 6; i++) begin
            cs   = i % 4;
            spol = i[0];
            len  = int'(VECS[i].lm1) + 1;
            expw = (len == 32) ? VECS[i].data : (VECS[i].data & ((32'd1 << len) - 32'd1));
            cfgw = (32'(VECS[i].pha) << cs) | (32'(VECS[i].pol) << (cs + 4)) |
                   (32'(spol) << (cs + 12)) | (32'(VECS[i].pol) << (cs + 20));
            wr(CFG, cfgw);
            v = 32'h1 | (32'(VECS[i].lm1) << 20) | (32'(cs) << 18) |
                (32'(VECS[i].pre) << 12) | (32'(VECS[i].post) << 8);
            wr(CTRL, v);
            wr(TXD, VECS[i].data);
            exp_n    = (int'(VECS[i].pre) + 1) << VECS[i].post;
            cap_rise = (VECS[i].pol == VECS[i].pha);
            mon_en   = 1;
            wr(CTRL, v | 32'h4);
            expw[31:0] = expw;
            chk($sformatf("R6 select asserted vec%0d", i), 32'(sel_out),
                32'(4'hF & ~(4'(1) << cs)) | (32'(spol) << cs));
            wait_done("R3 burst completes");
            chk($sformatf("R4 edge spacing vec%0d", i), 32'(space_err), 32'd0);
            chk($sformatf("R5 serial capture vec%0d", i), cap, expw);
            mon_en = 0;
            rd(RXD, v);
            chk($sformatf("R9 received word vec%0d", i), v, expw);
            chk($sformatf("R6 select released vec%0d", i), 32'(sel_out),
                32'(4'hF & ~(4'(spol) << cs)));
            chk($sformatf("R7 sclk rest level vec%0d", i), 32'(sclk), 32'(VECS[i].pol));
        end

        // R7 idle level independent of polarity
        wr(CTRL, 32'h0);
        wr(CFG, 32'h0010_0000);
        @(negedge clk);
        chk("R7 idle level high", 32'(sclk), 32'd1);
        wr(CFG, 32'h0020_0000);
        @(negedge clk);
        chk("R7 idle level of other line unused", 32'(sclk), 32'd0);
        wr(CFG, 32'h0);

        // R8 status and interrupt
        wr(IEN, 32'h8);
        @(negedge clk);
        chk("R8 irq off with rx empty", 32'(irq), 32'd0);
        wr(TXD, 32'h3C);
        wr(CTRL, 32'h0070_0005);
        wait_done("R8 exchange done");
        rd(STAT, v);  chk("R8 status rx ready", v, 32'h9);
        chk("R8 irq on rx ready", 32'(irq), 32'd1);
        rd(RXD, v);   chk("R8 rx data", v, 32'h3C);
        chk("R8 irq drops after pop", 32'(irq), 32'd0);
        wr(IEN, 32'h1);
        @(negedge clk);
        chk("R8 irq on tx empty", 32'(irq), 32'd1);
        wr(TXD, 32'h11);
        chk("R8 irq off tx pending", 32'(irq), 32'd0);
        wr(CTRL, 32'h0070_0005);
        wait_done("R8 second exchange");
        chk("R8 irq on tx drained", 32'(irq), 32'd1);
        rd(RXD, v);
        wr(IEN, 32'h0);

        // R2 overfill transmit queue while disabled
        wr(CTRL, 32'h0070_0000);
        for (int k = 1; k <= 65; k++) wr(TXD, 32'(k));
        rd(STAT, v);  chk("R2 tx not empty", v, 32'h0);
        wr(CTRL, 32'h0070_0005);
        wait_done("R2 drain 64");
        for (int k = 1; k <= 64; k++) begin
            rd(RXD, v);
            chk("R2 order after overfill", v, 32'(k));
        end
        rd(STAT, v);  chk("R2 extra word dropped", v, 32'h1);
        rd(RXD, v);   chk("R2 empty read returns zero", v, 32'd0);

        // R9 hold-off when receive queue is full
        for (int k = 101; k <= 164; k++) wr(TXD, 32'(k));
        wr(CTRL, 32'h0070_0005);
        wait_done("R9 fill receive queue");
        wr(TXD, 32'd200);
        wr(CTRL, 32'h0070_0005);
        repeat (50) @(negedge clk);
        rd(CTRL, v);  chk("R9 exchange held while rx full", 32'(v[2]), 32'd1);
        rd(STAT, v);  chk("R9 tx word still queued", v, 32'h8);
        rd(RXD, v);   chk("R9 oldest word kept", v, 32'd101);
        wait_done("R9 resumes after pop");
        for (int k = 102; k <= 164; k++) begin
            rd(RXD, v);
            chk("R9 no overwrite", v, 32'(k));
        end
        rd(RXD, v);   chk("R9 held word arrives last", v, 32'd200);

        // R3 disabling stops a pending exchange
        wr(TXD, 32'h5);
        wr(CTRL, 32'h0070_0000);
        rd(CTRL, v);  chk("R3 disable clears xch", v, 32'h0070_0000);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule